// File: doc/BRIEF.md
# Physical Page Frame Pool

This block keeps ownership records for a fixed pool of physical page frames. Each frame has an in-use flag, an owner process ID and a virtual page number. Software-side logic sends one command at a time. Four commands are supported:

- **Allocate** claims the lowest free frame.
- **Map** tags a frame with an owner and a virtual page.
- **Lookup** finds the frame that holds a given owner and virtual page.
- **Free** releases every frame of an owner and returns how many frames were released.

By default the pool has 512 frames of 4 KiB each, starting at physical page number 0x80400. The frame ID and that frame's physical page number are returned together.

Allocate and map finish one cycle after they are accepted. Lookup and free step through the table one entry per clock. While they do, busy is raised and any new command is dropped. Every command ends with a one-cycle done pulse, and the results are valid in that cycle. If an allocate finds no free frame, the error flag is raised and no frame ID is returned. A freed frame keeps its tags until it is mapped again, but a lookup never matches it.

Top module: `page_frame_pool`

## Requirements
- R1: After reset every frame is free, busy_o, done_o and err_o are low, and the first allocate returns frame 0.
- R2: Allocate (cmd_op_i = 0) returns the lowest-indexed free frame in frame_o and marks it in use. done_o pulses in the cycle after acceptance, with err_o low.
- R3: Allocate with no free frame pulses done_o with err_o high and changes no in-use flag.
- R4: Map (cmd_op_i = 1) writes the pid and virtual page into the entry of cmd_frame_i and leaves that entry's in-use flag as it was. A mapped free frame is therefore still returned by a later allocate, and a lookup does not find it. done_o pulses in the cycle after acceptance.
- R5: When frame_o is valid, ppn_o equals 0x80400 plus frame_o.
- R6: Lookup (cmd_op_i = 2) pulses done_o with hit_o high and frame_o set to the lowest in-use frame whose pid and virtual page both match. If no in-use frame matches, it pulses done_o with hit_o low after scanning every frame.
- R7: Free (cmd_op_i = 3) clears the in-use flag of every in-use frame tagged with cmd_pid_i and reports the number cleared in free_cnt_o. Released frames become available to allocate.
- R8: A command presented while busy_o is high is dropped. It changes no frame state and produces no result.
- R9: done_o is high for exactly one cycle per accepted command. busy_o is high during a lookup or free scan and is never high together with done_o.
- R10: free_cnt_o reaches 512 when one owner holds the whole pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_op_i | input | 2 | 0 allocate, 1 map, 2 lookup, 3 free |
| cmd_pid_i | input | 8 | Owner process ID |
| cmd_vpn_i | input | 20 | Virtual page number |
| cmd_frame_i | input | 9 | Frame ID for map |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Pool exhausted on allocate |
| hit_o | output | 1 | Lookup found a match |
| frame_o | output | 9 | Frame ID result |
| ppn_o | output | 20 | Physical page number of frame_o |
| free_cnt_o | output | 10 | Frames released by the last free |

## Verification
Errors in the in-use flags are the most damaging, and the bench detects them through the allocate command. Allocate reports the lowest free frame in the very next cycle, so a flag left set or wrongly cleared shows up as a wrong frame ID on the following allocate. Tag corruption appears only through lookup and free, and only after a scan of up to 512 cycles. It shows up as a wrong hit, a wrong frame or a wrong released count. A command that wrongly takes effect while busy is caught by the allocate or lookup issued right after that scan.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC  = 2'd0,
    OP_MAP    = 2'd1,
    OP_LOOKUP = 2'd2,
    OP_FREE   = 2'd3
  } ppa_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } ppa_state_e;
endpackage

// File: rtl/ppa_first_free.sv
module ppa_first_free #(
  parameter int N = 512
) (
  input  logic [N-1:0]         used_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IDX_W = $clog2(N);

  // descending walk: the last assignment wins, giving the lowest free index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ppa_table.sv
module ppa_table #(
  parameter int N     = 512,
  parameter int PID_W = 8,
  parameter int VPN_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic [$clog2(N)-1:0] set_idx_i,
  input  logic                 clr_en_i,
  input  logic [$clog2(N)-1:0] clr_idx_i,
  input  logic                 wr_en_i,
  input  logic [$clog2(N)-1:0] wr_idx_i,
  input  logic [PID_W-1:0]     wr_pid_i,
  input  logic [VPN_W-1:0]     wr_vpn_i,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  output logic                 rd_use_o,
  output logic [PID_W-1:0]     rd_pid_o,
  output logic [VPN_W-1:0]     rd_vpn_o,
  output logic [N-1:0]         use_vec_o
);
  logic [N-1:0]     use_q;
  logic [PID_W-1:0] pid_q [N];
  logic [VPN_W-1:0] vpn_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q <= '0;
    end else begin
      if (set_en_i) use_q[set_idx_i] <= 1'b1;
      if (clr_en_i) use_q[clr_idx_i] <= 1'b0;
    end
  end

  // tags need no reset: they are only consulted when the use flag is set
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      pid_q[wr_idx_i] <= wr_pid_i;
      vpn_q[wr_idx_i] <= wr_vpn_i;
    end
  end

  assign rd_use_o  = use_q[rd_idx_i];
  assign rd_pid_o  = pid_q[rd_idx_i];
  assign rd_vpn_o  = vpn_q[rd_idx_i];
  assign use_vec_o = use_q;
endmodule

// File: rtl/page_frame_pool.sv
module page_frame_pool
  import ppa_pkg::*;
#(
  parameter int               N_FRAMES = 512,
  parameter int               PID_W    = 8,
  parameter int               VPN_W    = 20,
  parameter logic [VPN_W-1:0] BASE_PPN = 20'h80400
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic [1:0]                  cmd_op_i,
  input  logic [PID_W-1:0]            cmd_pid_i,
  input  logic [VPN_W-1:0]            cmd_vpn_i,
  input  logic [$clog2(N_FRAMES)-1:0] cmd_frame_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic                        hit_o,
  output logic [$clog2(N_FRAMES)-1:0] frame_o,
  output logic [VPN_W-1:0]            ppn_o,
  output logic [$clog2(N_FRAMES+1)-1:0] free_cnt_o
);
  localparam int IDX_W = $clog2(N_FRAMES);
  localparam int CNT_W = $clog2(N_FRAMES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  ppa_state_e       state_q;
  ppa_op_e          op_q, done_op_q, cmd_op;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] idx_q, frame_q;
  logic [CNT_W-1:0] run_cnt_q, cnt_q, run_cnt_nx;
  logic             done_q, err_q, hit_q;

  logic                accept, ff_found;
  logic [IDX_W-1:0]    ff_idx;
  logic                set_en, clr_en, wr_en;
  logic                rd_use;
  logic [PID_W-1:0]    rd_pid;
  logic [VPN_W-1:0]    rd_vpn;
  logic [N_FRAMES-1:0] use_vec;
  logic                pid_match, lk_hit, last;

  assign cmd_op = ppa_op_e'(cmd_op_i);
  assign accept = cmd_valid_i && (state_q == ST_IDLE);

  ppa_first_free #(.N(N_FRAMES)) i_first_free (
    .used_i (use_vec),
    .found_o(ff_found),
    .idx_o  (ff_idx)
  );

  assign set_en    = accept && (cmd_op == OP_ALLOC) && ff_found;
  assign wr_en     = accept && (cmd_op == OP_MAP);
  assign pid_match = rd_use && (rd_pid == pid_q);
  assign lk_hit    = pid_match && (rd_vpn == vpn_q);
  assign clr_en    = (state_q == ST_SCAN) && (op_q == OP_FREE) && pid_match;
  assign last      = (idx_q == LAST_IDX);
  assign run_cnt_nx = run_cnt_q + CNT_W'(pid_match);

  ppa_table #(.N(N_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (set_en),
    .set_idx_i(ff_idx),
    .clr_en_i (clr_en),
    .clr_idx_i(idx_q),
    .wr_en_i  (wr_en),
    .wr_idx_i (cmd_frame_i),
    .wr_pid_i (cmd_pid_i),
    .wr_vpn_i (cmd_vpn_i),
    .rd_idx_i (idx_q),
    .rd_use_o (rd_use),
    .rd_pid_o (rd_pid),
    .rd_vpn_o (rd_vpn),
    .use_vec_o(use_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_ALLOC;
      done_op_q <= OP_ALLOC;
      pid_q     <= '0;
      vpn_q     <= '0;
      idx_q     <= '0;
      frame_q   <= '0;
      run_cnt_q <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept) begin
          unique case (cmd_op)
            OP_ALLOC: begin
              done_q    <= 1'b1;
              done_op_q <= OP_ALLOC;
              hit_q     <= 1'b0;
              err_q     <= !ff_found;
              if (ff_found) frame_q <= ff_idx;
            end
            OP_MAP: begin
              done_q    <= 1'b1;
              done_op_q <= OP_MAP;
              hit_q     <= 1'b0;
              err_q     <= 1'b0;
            end
            OP_LOOKUP, OP_FREE: begin
              state_q   <= ST_SCAN;
              op_q      <= cmd_op;
              pid_q     <= cmd_pid_i;
              vpn_q     <= cmd_vpn_i;
              idx_q     <= '0;
              run_cnt_q <= '0;
            end
          endcase
        end
      end else begin
        if (op_q == OP_LOOKUP) begin
          if (lk_hit || last) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            done_op_q <= OP_LOOKUP;
            err_q     <= 1'b0;
            hit_q     <= lk_hit;
            if (lk_hit) frame_q <= idx_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          if (last) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            done_op_q <= OP_FREE;
            err_q     <= 1'b0;
            hit_q     <= 1'b0;
            cnt_q     <= run_cnt_nx;
          end else begin
            run_cnt_q <= run_cnt_nx;
            idx_q     <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o     = (state_q == ST_SCAN);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign hit_o      = hit_q;
  assign frame_o    = frame_q;
  assign free_cnt_o = cnt_q;
  assign ppn_o      = BASE_PPN + VPN_W'(frame_q);

  // mask of frames strictly below frame_q, for the lowest-free check
  logic [N_FRAMES-1:0] below_mask;
  assign below_mask = ~({N_FRAMES{1'b1}} << frame_q);

  a_r2_alloc_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_op_q == OP_ALLOC && !err_o |->
      use_vec[frame_q] && ((use_vec & below_mask) == below_mask));

  a_r3_err_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_op_q == OP_ALLOC && err_o |-> &use_vec);

  a_r6_hit_in_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_op_q == OP_LOOKUP && hit_o |-> use_vec[frame_q]);

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_op_q == OP_FREE |-> free_cnt_o <= CNT_W'(N_FRAMES));

  a_r8_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q) && $stable(pid_q) && $stable(vpn_q));

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

// File: tb/test_page_frame_pool.sv
`timescale 1ns/1ps
module test_page_frame_pool;
  localparam int N  = 512;
  localparam int WD = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_pid = '0;
  logic [19:0] cmd_vpn = '0;
  logic [8:0] cmd_frame = '0;
  logic       busy_o, done_o, err_o, hit_o;
  logic [8:0] frame_o;
  logic [19:0] ppn_o;
  logic [9:0] free_cnt_o;

  int total = 0;
  int bad   = 0;
  logic       r_err, r_hit;
  logic [8:0] r_frame;
  logic [19:0] r_ppn;
  logic [9:0] r_cnt;

  always #10 clk = ~clk;

  page_frame_pool i_page_frame_pool (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_pid_i(cmd_pid), .cmd_vpn_i(cmd_vpn), .cmd_frame_i(cmd_frame),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .hit_o(hit_o),
    .frame_o(frame_o), .ppn_o(ppn_o), .free_cnt_o(free_cnt_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  pid;
    logic [19:0] vpn;
    logic [8:0]  fr;
    logic        hit;
    logic [8:0]  ef;
    logic [9:0]  ec;
  } vec_t;

  // op: 0 alloc, 1 map, 2 lookup, 3 free
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd1, 8'd7, 20'h803FF, 9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd1, 10'd0},
    '{2'd1, 8'd7, 20'h803FE, 9'd1, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd2, 10'd0},
    '{2'd1, 8'd9, 20'h803FF, 9'd2, 1'b0, 9'd0, 10'd0},
    '{2'd2, 8'd7, 20'h803FE, 9'd0, 1'b1, 9'd1, 10'd0},
    '{2'd2, 8'd9, 20'h803FF, 9'd0, 1'b1, 9'd2, 10'd0},
    '{2'd2, 8'd9, 20'h803FE, 9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd1, 8'd9, 20'h80400, 9'd5, 1'b0, 9'd0, 10'd0},
    '{2'd2, 8'd9, 20'h80400, 9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd3, 10'd0},
    '{2'd1, 8'd4, 20'h80200, 9'd3, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd4, 10'd0},
    '{2'd1, 8'd4, 20'h80201, 9'd4, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd5, 10'd0},
    '{2'd2, 8'd9, 20'h80400, 9'd0, 1'b1, 9'd5, 10'd0},
    '{2'd3, 8'd7, 20'h0,     9'd0, 1'b0, 9'd0, 10'd2},
    '{2'd2, 8'd7, 20'h803FF, 9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd3, 8'd9, 20'h0,     9'd0, 1'b0, 9'd0, 10'd2},
    '{2'd3, 8'd9, 20'h0,     9'd0, 1'b0, 9'd0, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd1, 10'd0},
    '{2'd0, 8'd0, 20'h0,     9'd0, 1'b0, 9'd2, 10'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] pid,
                        input logic [19:0] vpn, input logic [8:0] fr);
    int w;
    w = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pid = pid; cmd_vpn = vpn; cmd_frame = fr;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done_o && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk("R9 done seen", 32'(done_o), 32'd1);
    r_err = err_o; r_hit = hit_o; r_frame = frame_o; r_ppn = ppn_o; r_cnt = free_cnt_o;
    @(negedge clk);
    chk("R9 done single cycle", 32'(done_o), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    do_reset();
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);
    chk("R1 err after reset", 32'(err_o), 32'd0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      do_cmd(VEC[k].op, VEC[k].pid, VEC[k].vpn, VEC[k].fr);
      unique case (VEC[k].op)
        2'd0: begin
          chk("R2 alloc err", 32'(r_err), 32'd0);
          chk("R2 alloc frame", 32'(r_frame), 32'(VEC[k].ef));
          chk("R5 alloc ppn", 32'(r_ppn), 32'h80400 + 32'(VEC[k].ef));
        end
        2'd1: chk("R4 map err", 32'(r_err), 32'd0);
        2'd2: begin
          chk("R6 lookup hit", 32'(r_hit), 32'(VEC[k].hit));
          if (VEC[k].hit) begin
            chk("R6 lookup frame", 32'(r_frame), 32'(VEC[k].ef));
            chk("R5 lookup ppn", 32'(r_ppn), 32'h80400 + 32'(VEC[k].ef));
          end
        end
        2'd3: chk("R7 free count", 32'(r_cnt), 32'(VEC[k].ec));
      endcase
    end

    // R8: commands during a scan are dropped; frames 0..4 in use, 3/4 owned by pid 4
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pid = 8'd50; cmd_vpn = 20'h1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 busy during scan", 32'(busy_o), 32'd1);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_op = 2'd3; cmd_pid = 8'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 done low while busy", 32'(done_o), 32'd0);
    while (!done_o) @(negedge clk);
    chk("R6 scan miss", 32'(hit_o), 32'd0);
    chk("R9 busy low at done", 32'(busy_o), 32'd0);
    do_cmd(2'd0, 8'd0, 20'h0, 9'd0);
    chk("R8 ignored alloc", 32'(r_frame), 32'd5);
    do_cmd(2'd2, 8'd4, 20'h80200, 9'd0);
    chk("R8 ignored free hit", 32'(r_hit), 32'd1);
    chk("R8 ignored free frame", 32'(r_frame), 32'd3);

    // R1 again, then fill the pool for R3 and R10
    do_reset();
    for (int i = 0; i < N; i++) begin
      do_cmd(2'd0, 8'd0, 20'h0, 9'd0);
      chk("R1 R2 fill frame", 32'(r_frame), 32'(i));
      do_cmd(2'd1, 8'd3, 20'(i), 9'(i));
    end
    do_cmd(2'd0, 8'd0, 20'h0, 9'd0);
    chk("R3 full err", 32'(r_err), 32'd1);
    do_cmd(2'd2, 8'd3, 20'd511, 9'd0);
    chk("R6 last frame hit", 32'(r_hit), 32'd1);
    chk("R6 last frame id", 32'(r_frame), 32'd511);
    chk("R5 last ppn", 32'(r_ppn), 32'h805FF);
    do_cmd(2'd3, 8'd3, 20'h0, 9'd0);
    chk("R10 free all count", 32'(r_cnt), 32'd512);
    do_cmd(2'd0, 8'd0, 20'h0, 9'd0);
    chk("R7 reuse err", 32'(r_err), 32'd0);
    chk("R7 reuse frame", 32'(r_frame), 32'd0);

    summary();
    $finish;
  end
endmodule